// File: doc/BRIEF.md
# Clock-aligned 4:1 parallel-to-serial converter

This block turns a stream of 4-bit words into a serial bit stream running four times faster than the word rate. It is clocked by the fast serial-bit clock and produces a word-rate clock output, the serial clock divided by four. Upstream logic uses that output as its timing reference. It returns its own word clock together with the data. The returned clock may arrive anywhere from zero to about two and a half serial periods after the block's word-rate clock output.

Each word is caught in a holding register on the rising edge of the returned word clock. The block moves it into a shift register at a fixed count of its divide-by-four counter. That count is as far as possible from the window in which the capture edge may fall. Because of this, the same held word is loaded and sent regardless of where inside the window the returned clock lands. The serial output sends the most significant bit first and has no gaps between words.

Top module: `ser4_tx`

## Requirements
- R1: `wclk_out` is the serial clock divided by four with a 50% duty cycle: two serial cycles high, then two low, repeating.
- R2: While `rst` is high at a serial clock edge, `wclk_out` and `sdo` are driven low. `wclk_out` rises at the first serial edge with `rst` low; call that edge E0.
- R3: The word on `wdata` is captured on the rising edge of `wclk_in`. Changes to `wdata` at other times are not captured.
- R4: The shift register loads the held word at serial edge E0+3 of every word period, three serial cycles after each rising edge of `wclk_out`.
- R5: Bits leave most significant first. After the load edge, `sdo` carries bit 3, then bits 2, 1 and 0 on the following three edges.
- R6: Consecutive words follow with no idle bit: bit 3 of the next word comes on the edge right after bit 0 of the previous word.
- R7: A word captured by a `wclk_in` rising edge that lags a `wclk_out` rising edge at E by 0 to 2.5 serial periods is sent on edges E+3 to E+6. This latency is the same for every lag in that window.
- R8: `sdo` stays low from reset until the first word is loaded at E0+3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ser | input | 1 | Serial-bit clock |
| rst | input | 1 | Synchronous active-high reset |
| wclk_in | input | 1 | Word clock returned by upstream logic |
| wdata | input | W (4) | Parallel word, captured on `wclk_in` rising edge |
| wclk_out | output | 1 | Serial clock divided by four |
| sdo | output | 1 | Serial data output, MSB first |

## Verification
Two things can fall in the same serial cycle. A new word can be captured into the holding register while the previous word is still shifting out. The shift register can also load the next word on the same edge as the last bit of the previous word leaves. The bench drives the returned clock as a delayed copy of `wclk_out` and sweeps the lag over the whole window, from zero to two and a half serial periods and back. It sends fixed corner patterns and then random data. A monitor counts serial edges from reset on its own and rebuilds each word from `sdo` at a fixed slot. It compares each rebuilt word with the words queued at capture. Any slip in latency, bit order or word boundary shows up as a mismatch.

// File: rtl/ser4_pkg.sv
package ser4_pkg;
  // Width of a phase counter that counts 0 .. ratio-1.
  function automatic int unsigned phase_bits(input int unsigned ratio);
    return (ratio <= 2) ? 1 : $clog2(ratio);
  endfunction
endpackage

// File: rtl/ser4_phase_gen.sv
module ser4_phase_gen #(
  parameter int unsigned W = 4
) (
  input  logic clk_ser,
  input  logic rst,
  output logic wclk_out,
  output logic load_now
);
  import ser4_pkg::*;
  localparam int unsigned PW = phase_bits(W);
  localparam logic [PW-1:0] LAST    = PW'(W - 1);
  localparam logic [PW-1:0] LOAD_AT = PW'(W - 2);
  localparam logic [PW-1:0] HALF    = PW'(W / 2);

  logic [PW-1:0] phase;
  logic [PW-1:0] phase_nx;

  always_comb begin
    phase_nx = (phase == LAST) ? '0 : phase + 1'b1;
  end

  always_ff @(posedge clk_ser) begin
    if (rst) begin
      phase    <= LAST;
      wclk_out <= 1'b0;
    end else begin
      phase    <= phase_nx;
      wclk_out <= (phase_nx < HALF);
    end
  end

  // Load on the edge that moves the phase to its last value.
  assign load_now = (phase == LOAD_AT);
endmodule

// File: rtl/ser4_hold_reg.sv
module ser4_hold_reg #(
  parameter int unsigned W = 4
) (
  input  logic         wclk_in,
  input  logic         rst,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] hold_q
);
  always_ff @(posedge wclk_in) begin
    if (rst) hold_q <= '0;
    else     hold_q <= wdata;
  end
endmodule

// File: rtl/ser4_shifter.sv
module ser4_shifter #(
  parameter int unsigned W = 4
) (
  input  logic         clk_ser,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic         sdo
);
  logic [W-1:0] sr;

  always_ff @(posedge clk_ser) begin
    if (rst) begin
      sr  <= '0;
      sdo <= 1'b0;
    end else if (load) begin
      sdo <= din[W-1];
      sr  <= {din[W-2:0], 1'b0};
    end else begin
      sdo <= sr[W-1];
      sr  <= {sr[W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/ser4_tx.sv
// W is the serialization ratio; it must be even and at least 4.
module ser4_tx #(
  parameter int unsigned W = 4
) (
  input  logic         clk_ser,
  input  logic         rst,
  input  logic         wclk_in,
  input  logic [W-1:0] wdata,
  output logic         wclk_out,
  output logic         sdo
);
  logic         load_now;
  logic [W-1:0] hold_q;

  ser4_phase_gen #(.W(W)) u_phase (
    .clk_ser  (clk_ser),
    .rst      (rst),
    .wclk_out (wclk_out),
    .load_now (load_now)
  );

  ser4_hold_reg #(.W(W)) u_hold (
    .wclk_in (wclk_in),
    .rst     (rst),
    .wdata   (wdata),
    .hold_q  (hold_q)
  );

  ser4_shifter #(.W(W)) u_shift (
    .clk_ser (clk_ser),
    .rst     (rst),
    .load    (load_now),
    .din     (hold_q),
    .sdo     (sdo)
  );
endmodule

// File: rtl/ser4_tx_chk.sv
module ser4_tx_chk #(
  parameter int unsigned W = 4
) (
  input logic         clk_ser,
  input logic         rst,
  input logic         wclk_out,
  input logic         load_now,
  input logic [W-1:0] hold_q,
  input logic         sdo
);
  assert_wclk_high_two_R1: assert property (@(posedge clk_ser) disable iff (rst)
    $rose(wclk_out) |=> wclk_out);

  assert_wclk_low_two_R1: assert property (@(posedge clk_ser) disable iff (rst)
    $fell(wclk_out) |=> !wclk_out);

  assert_wclk_falls_R1: assert property (@(posedge clk_ser) disable iff (rst)
    (wclk_out && $past(wclk_out)) |=> !wclk_out);

  assert_reset_low_R2: assert property (@(posedge clk_ser) disable iff (rst)
    $past(rst) |-> (!wclk_out && !sdo));

  assert_load_phase_R4: assert property (@(posedge clk_ser) disable iff (rst)
    load_now |-> !wclk_out);

  assert_no_load_at_rise_R4: assert property (@(posedge clk_ser) disable iff (rst)
    $rose(wclk_out) |-> !load_now);

  assert_msb_first_R5: assert property (@(posedge clk_ser) disable iff (rst)
    $past(load_now) |-> (sdo == $past(hold_q[W-1])));

  assert_second_bit_R5: assert property (@(posedge clk_ser) disable iff (rst)
    $past(load_now, 2) |-> (sdo == $past(hold_q[W-2], 2)));
endmodule

bind ser4_tx ser4_tx_chk #(.W(W)) u_chk (
  .clk_ser  (clk_ser),
  .rst      (rst),
  .wclk_out (wclk_out),
  .load_now (load_now),
  .hold_q   (hold_q),
  .sdo      (sdo)
);

// File: tb/ser4_tx_test.sv
`timescale 1ns/1ps
module ser4_tx_test;
  localparam int W = 4;

  logic         clk_ser = 1'b0;
  logic         rst = 1'b1;
  logic         wclk_in = 1'b0;
  logic [W-1:0] wdata = '0;
  logic         wclk_out;
  logic         sdo;

  int checks = 0;
  int failures = 0;
  int compared = 0;
  int k = 0;            // serial edges since reset release (E0 gives 1)
  real skew = 0.0;      // lag of wclk_in after wclk_out, ns
  logic [W-1:0] exp_q[$];
  logic [W-1:0] acc;

  ser4_tx #(.W(W)) uut (
    .clk_ser  (clk_ser),
    .rst      (rst),
    .wclk_in  (wclk_in),
    .wdata    (wdata),
    .wclk_out (wclk_out),
    .sdo      (sdo)
  );

  always #2 clk_ser = ~clk_ser;   // 250 MHz

  always @(posedge clk_ser) begin
    if (rst) k <= 0;
    else     k <= k + 1;
  end

  function automatic real skew_of(input int n);
    case ((n / 10) % 11)
      0: return 0.0;  1: return 1.0;  2: return 2.5;  3: return 4.0;
      4: return 5.0;  5: return 6.5;  6: return 7.5;  7: return 9.0;
      8: return 10.0; 9: return 4.0;  default: return 1.0;
    endcase
  endfunction

  function automatic logic [W-1:0] word_of(input int n);
    case (n)
      0: return 4'hF; 1: return 4'h0; 2: return 4'hA; 3: return 4'h5;
      4: return 4'h8; 5: return 4'h1; 6: return 4'h7; 7: return 4'hE;
      default: return W'($urandom);
    endcase
  endfunction

  // Driver: returned word clock is wclk_out delayed by skew; data changes at its fall.
  initial begin
    int n;
    n = 0;
    wdata = word_of(0);
    wait (!rst);
    forever begin
      @(posedge wclk_out);
      if (skew > 0.0) #(skew);
      wclk_in = 1'b1;
      exp_q.push_back(wdata);
      #5;
      wclk_in = 1'b0;
      n = n + 1;
      wdata = word_of(n);
      skew = skew_of(n);
    end
  end

  // Monitor: phase derived from the bench's own edge count.
  always @(negedge clk_ser) begin
    if (rst) begin
      checks++;
      if (wclk_out !== 1'b0 || sdo !== 1'b0) begin
        failures++;
        $display("FAIL R2 reset outputs actual wclk_out=%b sdo=%b expected 0 0", wclk_out, sdo);
      end
    end else if (k > 0) begin
      checks++;
      if (wclk_out !== (((k - 1) % 4) < 2)) begin
        failures++;
        $display("FAIL R1 wclk_out at edge %0d actual=%b expected=%b", k, wclk_out, (((k - 1) % 4) < 2));
      end
      if (k < 4) begin
        checks++;  // R8: idle low before the first load
        if (sdo !== 1'b0) begin
          failures++;
          $display("FAIL R8 sdo before first load actual=%b expected=0", sdo);
        end
      end else begin
        int bi;
        bi = 3 - ((k - 4) % 4);
        acc[bi] = sdo;
        if (bi == 0) begin
          logic [W-1:0] ew;
          checks++;  // R3 R4 R5 R6 R7: word slot fixed for every skew
          if (exp_q.size() == 0) begin
            failures++;
            $display("FAIL R7 word out with nothing captured actual=%h expected=none", acc);
          end else begin
            ew = exp_q.pop_front();
            if (acc !== ew) begin
              failures++;
              $display("FAIL R3/R4/R5/R6/R7 word %0d skew=%0.1f actual=%h expected=%h",
                       compared, skew, acc, ew);
            end
          end
          compared++;
        end
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk_ser);
    rst = 1'b0;
    fork
      wait (compared >= 130);
      begin
        repeat (20000) @(posedge clk_ser);
        failures++;
        $display("FAIL R7 watchdog actual=%0d words expected=130", compared);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule